// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block sits between a simple on-chip request port and an external asynchronous static RAM of 512K words by 16 bits whose two byte lanes are gated by separate active-low strobes. A client raises a request with a read/write flag, a 19-bit word address, 16-bit write data and a 2-bit lane mask. The controller then drives chip enable, output enable, write enable and the two lane strobes for the number of clock cycles each memory timing minimum needs. It returns one done pulse, with the read data on a read.

Every timing window is a parameter in nanoseconds together with the clock period. The cycle counts are derived as rounded-up quotients with a floor of one. On a write, the controller does not drive the shared data lines until the memory has had time to release them after write enable falls. It keeps driving them for one cycle after write enable rises, so data hold is met. The bidirectional data bus is presented as separate input, output and output-enable signals, and the pad tri-state sits outside the block.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, memCeN, memOeN, memWeN and both bits of memLaneN are 1, memDqOe is 0 and rspDone is 0.
- R2: A read request accepted in idle (reqValid=1, reqWrite=0) gives memCeN=0, memOeN=0, memWeN=1 for exactly RD_CYC consecutive cycles, starting the cycle after acceptance. memLaneN bit 0 (lower lane, data bits 7:0) is 0 exactly when reqByteEn bit 0 is 1, and memLaneN bit 1 (upper lane, bits 15:8) is 0 exactly when reqByteEn bit 1 is 1.
- R3: Read data is sampled from memDqIn on the last of the RD_CYC strobe cycles. It appears on rspRdata together with rspDone in the following cycle, and a lane not enabled in the mask reads as zero.
- R4: A write request accepted in idle gives memCeN=0, memWeN=0, memOeN=1 and the lane strobes as in R2 for exactly WE_CYC consecutive cycles.
- R5: During a write, memDqOe stays 0 for the first WHZ_CYC cycles of write enable low, then is 1 with memDqOut equal to the request's write data. memDqOe is never 1 while memOeN is 0.
- R6: In the cycle after memWeN rises, memDqOe is still 1 with the same data and address, memCeN is 0 and both lane strobes are 1. In the cycle after that, memDqOe is 0.
- R7: memAddr holds the accepted address, unchanged for every cycle memCeN is low.
- R8: rspDone is high for exactly one cycle per access: after a read's last strobe cycle, or after a write's hold cycle. Requests presented while an access is in progress are ignored, and the controller returns to idle after done.
- R9: RD_CYC is the larger of the rounded-up read-cycle and access times over the clock period. WHZ_CYC is the rounded-up turnaround time. WE_CYC is the largest of the write-pulse, address-to-end, lane-to-end and (write-cycle minus one) counts, and of WHZ_CYC plus the data-overlap count. Every count is at least 1.
- R10: An access with a zero lane mask runs its full timing with both lane strobes at 1 and still ends with one done pulse. A read with a zero mask returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present; taken only when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Word address |
| reqWdata | input | 16 | Write data |
| reqByteEn | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rspRdata | output | 16 | Captured read data |
| rspDone | output | 1 | One-cycle completion pulse |
| memAddr | output | 19 | Memory address |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memLaneN | output | 2 | Lane strobes, active low, bit 0 lower byte |
| memDqOut | output | 16 | Data driven towards the memory |
| memDqOe | output | 1 | Drive enable for memDqOut |
| memDqIn | input | 16 | Data returned by the memory |

## Verification
A corrupted state or cycle counter shows up at once as a strobe window that is one cycle too short or too long. That is visible on memCeN or memWeN in the first cycle after the expected edge, or as a done pulse that arrives early, late or twice. A wrong lane mask or bad capture timing shows in the read-back value of the same access. Each write is checked against a bench memory model that is written through the pins. A wrong turnaround count shows as memDqOe rising in one of the first cycles of write enable low, and the checker flags that in that same cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_HOLD  = 2'd3
  } ctrlState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic latchReq;    // capture request fields this edge
    logic captureRd;   // sample memory read data this edge
    logic laneActive;  // lane strobes may be asserted this cycle
    logic driveBus;    // drive write data this cycle
  } dpStrobes_t;

  // Rounded-up cycles for a nanosecond minimum, never below one.
  function automatic int cyclesFor(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC  = 7,
  parameter int WE_CYC  = 8,
  parameter int WHZ_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       memCeN,
  output logic       memOeN,
  output logic       memWeN,
  output dpStrobes_t strobes,
  output logic       rspDone
);

  localparam int CNT_W = $clog2(maxOf(RD_CYC, WE_CYC) + 1);
  localparam logic [CNT_W-1:0] LAST_RD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_WE = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_AT  = CNT_W'(WHZ_CYC);

  ctrlState_e       state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             latchReq, captureRd, doneNxt;
  logic             laneActiveQ, driveBusQ;

  always_comb begin
    stateNxt  = state;
    cntNxt    = cnt;
    latchReq  = 1'b0;
    captureRd = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          latchReq = 1'b1;
          cntNxt   = '0;
          stateNxt = reqWrite ? ST_WRITE : ST_READ;
        end
      end
      ST_READ: begin
        if (cnt == LAST_RD) begin
          captureRd = 1'b1;
          cntNxt    = '0;
          stateNxt  = ST_IDLE;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      ST_WRITE: begin
        if (cnt == LAST_WE) begin
          cntNxt   = '0;
          stateNxt = ST_HOLD;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      ST_HOLD: begin
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign doneNxt = captureRd || (state == ST_HOLD);

  // Memory controls are registered from the next state: glitch-free pins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      memCeN      <= 1'b1;
      memOeN      <= 1'b1;
      memWeN      <= 1'b1;
      laneActiveQ <= 1'b0;
      driveBusQ   <= 1'b0;
      rspDone     <= 1'b0;
    end else begin
      state       <= stateNxt;
      cnt         <= cntNxt;
      memCeN      <= (stateNxt == ST_IDLE);
      memOeN      <= (stateNxt != ST_READ);
      memWeN      <= (stateNxt != ST_WRITE);
      laneActiveQ <= (stateNxt == ST_READ) || (stateNxt == ST_WRITE);
      driveBusQ   <= ((stateNxt == ST_WRITE) && (cntNxt >= DRV_AT)) ||
                     (stateNxt == ST_HOLD);
      rspDone     <= doneNxt;
    end
  end

  always_comb begin
    strobes.latchReq   = latchReq;
    strobes.captureRd  = captureRd;
    strobes.laneActive = laneActiveQ;
    strobes.driveBus   = driveBusQ;
  end

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqByteEn,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [LANES-1:0]  memLaneN,
  output logic [DATA_W-1:0] rspRdata
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
    end else if (strobes.latchReq) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      maskQ  <= reqByteEn;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    // Disabled lanes read back as zero.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdataQ[g*LANE_W +: LANE_W] <= '0;
      end else if (strobes.captureRd) begin
        rdataQ[g*LANE_W +: LANE_W] <= maskQ[g] ? memDqIn[g*LANE_W +: LANE_W]
                                               : '0;
      end
    end
    assign memLaneN[g] = !(strobes.laneActive && maskQ[g]);
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;
  assign memDqOe  = strobes.driveBus;
  assign rspRdata = rdataQ;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 16,
  parameter int LANES     = 2,
  parameter int CLK_NS    = 8,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_WC_NS   = 55,
  parameter int T_WP_NS   = 45,
  parameter int T_AW_NS   = 50,
  parameter int T_BW_NS   = 45,
  parameter int T_WHZ_NS  = 30,
  parameter int T_DW_NS   = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqByteEn,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [LANES-1:0]  memLaneN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  // R9: cycle counts from nanosecond minimums
  localparam int RD_CYC  = maxOf(cyclesFor(T_RC_NS, CLK_NS), cyclesFor(T_AA_NS, CLK_NS));
  localparam int WHZ_CYC = cyclesFor(T_WHZ_NS, CLK_NS);
  localparam int WE_CYC  = maxOf(maxOf(cyclesFor(T_WP_NS, CLK_NS), cyclesFor(T_AW_NS, CLK_NS)),
                                 maxOf(cyclesFor(T_BW_NS, CLK_NS),
                                       maxOf(WHZ_CYC + cyclesFor(T_DW_NS, CLK_NS),
                                             cyclesFor(T_WC_NS, CLK_NS) - 1)));

  dpStrobes_t strobes;

  sram_ctrl_fsm #(
    .RD_CYC (RD_CYC),
    .WE_CYC (WE_CYC),
    .WHZ_CYC(WHZ_CYC)
  ) i_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .memCeN  (memCeN),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .strobes (strobes),
    .rspDone (rspDone)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqByteEn(reqByteEn),
    .memDqIn  (memDqIn),
    .memAddr  (memAddr),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe),
    .memLaneN (memLaneN),
    .rspRdata (rspRdata)
  );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int ADDR_W  = 19,
  parameter int LANES   = 2,
  parameter int WHZ_CYC = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic [LANES-1:0]  memLaneN,
  input logic              memDqOe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              rspDone
);

  // Cycles write enable has already been low before the current cycle.
  int unsigned weLowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        weLowCnt <= 0;
    else if (memWeN)  weLowCnt <= 0;
    else              weLowCnt <= weLowCnt + 1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    memCeN |-> (memOeN && memWeN && (&memLaneN) && !memDqOe));

  assert_write_enable_needs_chip_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCeN && memOeN));

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && memDqOe) |-> (weLowCnt >= 32'(WHZ_CYC)));

  assert_hold_after_we_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (memDqOe && !memCeN && (&memLaneN)));

  assert_release_after_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |=> !memDqOe);

  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && !$past(memCeN)) |-> $stable(memAddr));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

endmodule

bind sram_lane_ctrl sram_ctrl_checker #(
  .ADDR_W (ADDR_W),
  .LANES  (LANES),
  .WHZ_CYC(WHZ_CYC)
) i_checker (
  .clk     (clk),
  .rstN    (rstN),
  .memCeN  (memCeN),
  .memOeN  (memOeN),
  .memWeN  (memWeN),
  .memLaneN(memLaneN),
  .memDqOe (memDqOe),
  .memAddr (memAddr),
  .rspDone (rspDone)
);

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;

  // Independent cycle arithmetic for an 8 ns clock (R9).
  function automatic int ceilDiv(input int ns);
    int c;
    c = (ns + 7) / 8;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD  = mx(ceilDiv(55), ceilDiv(55));
  localparam int WHZ = ceilDiv(30);
  localparam int WE  = mx(mx(ceilDiv(45), ceilDiv(50)),
                          mx(ceilDiv(45), mx(WHZ + ceilDiv(25), ceilDiv(55) - 1)));

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqByteEn = '0;
  logic [15:0] rspRdata;
  logic        rspDone;
  logic [18:0] memAddr;
  logic        memCeN, memOeN, memWeN, memDqOe;
  logic [1:0]  memLaneN;
  logic [15:0] memDqOut;
  logic [15:0] memDqIn;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sram_lane_ctrl i_sram_lane_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqByteEn(reqByteEn),
    .rspRdata(rspRdata), .rspDone(rspDone), .memAddr(memAddr),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .memLaneN(memLaneN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // Pin-level memory model, 16 words keyed by the low address nibble.
  logic [15:0] modelMem [16];
  logic [15:0] refMem [16];

  function automatic logic [15:0] seedWord(input int i);
    return 16'((i * 16'h1111) ^ 16'h5A3C);
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) begin
      modelMem[i] = seedWord(i);
      refMem[i]   = seedWord(i);
    end
  end

  always @(posedge clk) begin
    if (!memCeN && !memWeN && memDqOe) begin
      if (!memLaneN[0]) modelMem[memAddr[3:0]][7:0]  <= memDqOut[7:0];
      if (!memLaneN[1]) modelMem[memAddr[3:0]][15:8] <= memDqOut[15:8];
    end
  end

  always_comb begin
    if (!memCeN && !memOeN && memWeN)
      memDqIn = {memLaneN[1] ? 8'hEE : modelMem[memAddr[3:0]][15:8],
                 memLaneN[0] ? 8'h77 : modelMem[memAddr[3:0]][7:0]};
    else
      memDqIn = 16'hBEEF;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkIdle(input string tag);
    check(memCeN && memOeN && memWeN && (memLaneN == 2'b11) && !memDqOe, tag,
          {27'd0, memCeN, memOeN, memWeN, memLaneN}, 32'h1F);
  endtask

  task automatic doRead(input logic [18:0] a, input logic [1:0] m);
    logic [15:0] exp;
    exp = {m[1] ? refMem[a[3:0]][15:8] : 8'h00, m[0] ? refMem[a[3:0]][7:0] : 8'h00};
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqByteEn = m; reqWdata = 16'h0;
    @(negedge clk);
    // R8: a different request is held while busy and must be ignored
    reqWrite = 1'b1; reqAddr = ~a; reqByteEn = ~m;
    for (int i = 0; i < RD; i++) begin
      if (i > 0) @(negedge clk);
      check(!memCeN && !memOeN && memWeN, "R2 read strobes",
            {29'd0, memCeN, memOeN, memWeN}, 32'h1);
      check(memLaneN == ~m, (m == 2'b00) ? "R10 lanes off" : "R2 lane strobes",
            {30'd0, memLaneN}, {30'd0, ~m});
      check(memAddr == a && !memDqOe && !rspDone, "R7 read addr/bus",
            {13'd0, memAddr}, {13'd0, a});
      if (i == RD - 1) reqValid = 1'b0;
    end
    @(negedge clk);
    // R9: read window ended after exactly RD cycles
    check(rspDone, "R8 read done", {31'd0, rspDone}, 32'd1);
    check(rspRdata == exp, (m == 2'b00) ? "R10 zero-mask read" : "R3 read data",
          {16'd0, rspRdata}, {16'd0, exp});
    checkIdle("R9 read length");
    @(negedge clk);
    check(!rspDone, "R8 done one cycle", {31'd0, rspDone}, 32'd0);
    checkIdle("R8 busy request ignored");
  endtask

  task automatic doWrite(input logic [18:0] a, input logic [1:0] m, input logic [15:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqByteEn = m; reqWdata = d;
    @(negedge clk);
    reqWrite = 1'b0; reqAddr = ~a; reqByteEn = ~m; reqWdata = ~d;
    for (int i = 0; i < WE; i++) begin
      if (i > 0) @(negedge clk);
      check(!memCeN && memOeN && !memWeN, "R4 write strobes",
            {29'd0, memCeN, memOeN, memWeN}, 32'h2);
      check(memLaneN == ~m, (m == 2'b00) ? "R10 lanes off" : "R4 lane strobes",
            {30'd0, memLaneN}, {30'd0, ~m});
      check(memDqOe == (i >= WHZ), "R5 turnaround", {31'd0, memDqOe},
            {31'd0, (i >= WHZ)});
      if (i >= WHZ)
        check(memDqOut == d, "R5 write data", {16'd0, memDqOut}, {16'd0, d});
      check(memAddr == a && !rspDone, "R7 write addr", {13'd0, memAddr}, {13'd0, a});
    end
    @(negedge clk);
    reqValid = 1'b0;
    check(memWeN && memDqOe && !memCeN && memLaneN == 2'b11, "R6 hold cycle",
          {28'd0, memWeN, memDqOe, memLaneN}, 32'hF);
    check(memDqOut == d && memAddr == a && !rspDone, "R6 hold data",
          {16'd0, memDqOut}, {16'd0, d});
    @(negedge clk);
    check(rspDone, "R8 write done", {31'd0, rspDone}, 32'd1);
    checkIdle("R6 release after hold");
    @(negedge clk);
    check(!rspDone, "R8 done one cycle", {31'd0, rspDone}, 32'd0);
    checkIdle("R8 busy request ignored");
    if (m[0]) refMem[a[3:0]][7:0]  = d[7:0];
    if (m[1]) refMem[a[3:0]][15:8] = d[15:8];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R1 in reset");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle("R1 after reset");
    check(!rspDone && rspRdata == 16'h0, "R1 response reset", {16'd0, rspRdata}, 32'd0);
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 16; a++) begin
        logic [18:0] adr;
        logic [15:0] dat;
        adr = {4'(a), 11'(a * 181 + m * 97), 4'(a)};
        dat = 16'((a * 16'h0F1D) + (m * 16'h3301) + 16'h0042);
        doWrite(adr, 2'(m), dat);
        doRead(adr, 2'((m + a) % 4));
        doRead(adr, 2'b11);
      end
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule